// File: doc/BRIEF.md
# Watchpoint-to-Breakpoint Qualification Unit

This unit sits between a bank of external watchpoint comparators and the processor core's debug exception entry. Each cycle it receives one match pulse per watchpoint channel. It decides whether that pulse becomes a breakpoint request. Every raw match pulse is also passed through to a set of watchpoint output pins, with no qualification.

A channel is armed when either of its two enable bits is set. One bit is written by software and the other by the debug port. A channel can be held off while the core reports that its state is not restartable. A channel set to non-masked mode ignores that restriction. The two lowest channels have occurrence counters, so a breakpoint can be raised only on the Nth qualifying match. Two external breakpoint inputs, one maskable and one non-maskable, are merged into the same request line.

All inputs are plain control pins sampled on the rising clock edge. No input or output carries a data stream, so there is no valid/ready handshake and no back-pressure. Every output is a one-cycle pulse from a register, and a request that is blocked is dropped rather than held.

Top module: `wp_bp_qual`

## Requirements
- R1: `wp_pins[i]` equals `wp_hit[i]` from the previous cycle. This holds whatever the enables, the mode and `restartable` are.
- R2: A channel is armed when `sw_trap_en[i] | dp_trap_en[i]` is 1. A match on an unarmed channel never produces a `bp_pulse`.
- R3: A channel with `nomask_en[i]=0` is in masked mode. It produces a breakpoint only if `restartable` is 1 in the cycle of the match.
- R4: A channel with `nomask_en[i]=1` produces breakpoints whatever the value of `restartable`.
- R5: Channels 2 and 3 have no counter, and a counted channel whose preset is 0 behaves the same way. Such a channel pulses `bp_pulse[i]` one cycle after every qualifying match. A qualifying match is a match on an armed channel that R3 or R4 lets through.
- R6: A counted channel (0 or 1) with preset N>0 counts down once per qualifying match. It pulses on the match that takes the count from 1 to 0, then reloads N. It therefore fires on qualifying matches N, 2N, 3N and so on.
- R7: A match that is blocked by masking does not change the counter.
- R8: A blocked request is dropped. No `bp_pulse` appears later unless there is a new qualifying match.
- R9: A match on an unarmed channel does not change its counter. Clearing and then setting the enables also leaves the counter unchanged.
- R10: When `preset_wr[k]` is 1, counter k loads its preset and its count from `preset_val[16k+15:16k]`. In that cycle a match on channel k neither fires nor counts.
- R11: `ext_bp` pulses one cycle after `ext_nmi_req`, or after `ext_mask_req` while `restartable` is 1. A maskable request that arrives while `restartable` is 0 is dropped.
- R12: `bp_req` pulses in the same cycle as any `bp_pulse` bit or `ext_bp`.
- R13: After reset all outputs are 0 and both presets are 0, so a counted channel fires on its first qualifying match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_hit | input | 4 | Watchpoint match pulses from the comparators |
| sw_trap_en | input | 4 | Software-written arming bits |
| dp_trap_en | input | 4 | Debug-port-written arming bits |
| nomask_en | input | 4 | Per channel: 1 selects non-masked mode |
| restartable | input | 1 | Core reports a restartable machine state |
| preset_wr | input | 2 | Load strobe for each occurrence counter |
| preset_val | input | 32 | Preset values; counter k uses bits 16k+15:16k |
| ext_mask_req | input | 1 | Maskable external breakpoint request |
| ext_nmi_req | input | 1 | Non-maskable external breakpoint request |
| wp_pins | output | 4 | Registered copy of the raw watchpoint pulses |
| bp_pulse | output | 4 | One-cycle breakpoint pulse for each channel |
| ext_bp | output | 1 | Accepted external breakpoint pulse |
| bp_req | output | 1 | Combined breakpoint request to the core |

## Verification
Every result of this block comes out of a single register stage. `wp_pins`, `bp_pulse`, `ext_bp` and `bp_req` all reflect the inputs sampled at the previous rising edge, and counter updates take effect for the match at the next edge. The bench applies each stimulus on a falling edge and pushes the expected outputs for that stimulus. Two nanoseconds after the following rising edge, the monitor pops that item and compares it, so each comparison falls exactly one cycle after the matching stimulus. Counted-channel sequences therefore check every intermediate cycle, including the silent ones before the Nth match.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  localparam int unsigned WBQ_CHANNELS = 4;
  localparam int unsigned WBQ_COUNTED  = 2;
  localparam int unsigned WBQ_CNT_W    = 16;

  typedef enum logic {
    GATE_MASKED = 1'b0,
    GATE_OPEN   = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/wbq_qualify.sv
module wbq_qualify
  import wbq_pkg::*;
(
  input  logic hit,
  input  logic sw_en,
  input  logic dp_en,
  input  logic nomask,
  input  logic restartable,
  output logic qual
);
  gate_mode_e mode;
  logic       armed;
  logic       pass;

  always_comb begin
    mode  = nomask ? GATE_OPEN : GATE_MASKED;
    armed = sw_en | dp_en;
    pass  = (mode == GATE_OPEN) | restartable;
    qual  = hit & armed & pass;
  end
endmodule

// File: rtl/wbq_occ_counter.sv
module wbq_occ_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             fire
);
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] count_q;
  logic             last_one;

  assign last_one = (count_q <= CNT_W'(1));
  assign fire     = qual & ~load & last_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      preset_q <= load_val;
      count_q  <= load_val;
    end else if (qual) begin
      count_q  <= last_one ? preset_q : count_q - CNT_W'(1);
    end
  end

  // R7 / R9: no qualifying match and no load -> count frozen
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual && !load) |=> $stable(count_q));

  // R10: load takes the written value
  p_load_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val) && preset_q == $past(load_val)));

  // R6: firing reloads the preset
  p_fire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (count_q == preset_q));
endmodule

// File: rtl/wbq_ext_merge.sv
module wbq_ext_merge (
  input  logic mask_req,
  input  logic nmi_req,
  input  logic restartable,
  output logic take
);
  assign take = nmi_req | (mask_req & restartable);
endmodule

// File: rtl/wp_bp_qual.sv
module wp_bp_qual
  import wbq_pkg::*;
#(
  parameter int unsigned NUM_WP  = WBQ_CHANNELS,
  parameter int unsigned NUM_CNT = WBQ_COUNTED,
  parameter int unsigned CNT_W   = WBQ_CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WP-1:0]        wp_hit,
  input  logic [NUM_WP-1:0]        sw_trap_en,
  input  logic [NUM_WP-1:0]        dp_trap_en,
  input  logic [NUM_WP-1:0]        nomask_en,
  input  logic                     restartable,
  input  logic [NUM_CNT-1:0]       preset_wr,
  input  logic [NUM_CNT*CNT_W-1:0] preset_val,
  input  logic                     ext_mask_req,
  input  logic                     ext_nmi_req,
  output logic [NUM_WP-1:0]        wp_pins,
  output logic [NUM_WP-1:0]        bp_pulse,
  output logic                     ext_bp,
  output logic                     bp_req
);
  logic [NUM_WP-1:0] qual_vec;
  logic [NUM_WP-1:0] fire_vec;
  logic              ext_take;

  for (genvar i = 0; i < NUM_WP; i++) begin : g_chan
    wbq_qualify u_qual (
      .hit         (wp_hit[i]),
      .sw_en       (sw_trap_en[i]),
      .dp_en       (dp_trap_en[i]),
      .nomask      (nomask_en[i]),
      .restartable (restartable),
      .qual        (qual_vec[i])
    );

    if (i < NUM_CNT) begin : g_counted
      wbq_occ_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual_vec[i]),
        .load     (preset_wr[i]),
        .load_val (preset_val[i*CNT_W +: CNT_W]),
        .fire     (fire_vec[i])
      );
    end else begin : g_direct
      assign fire_vec[i] = qual_vec[i];
    end

    // R2: breakpoint only from an armed channel
    p_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bp_pulse[i] |-> $past(sw_trap_en[i] | dp_trap_en[i]));

    // R3 / R4: masked channel fires only when restartable
    p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bp_pulse[i] |-> $past(nomask_en[i] | restartable));

    // R1: raw pins follow the match one cycle later
    p_wp_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wp_hit[i]) |-> wp_pins[i]);
  end

  wbq_ext_merge u_ext (
    .mask_req    (ext_mask_req),
    .nmi_req     (ext_nmi_req),
    .restartable (restartable),
    .take        (ext_take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_pins  <= '0;
      bp_pulse <= '0;
      ext_bp   <= 1'b0;
      bp_req   <= 1'b0;
    end else begin
      wp_pins  <= wp_hit;
      bp_pulse <= fire_vec;
      ext_bp   <= ext_take;
      bp_req   <= (|fire_vec) | ext_take;
    end
  end

  // R11: non-maskable external request is always taken
  p_ext_nmi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ext_nmi_req) |-> ext_bp);

  // R11: a maskable-only request needs restartable
  p_ext_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_bp && !$past(ext_nmi_req)) |-> $past(restartable && ext_mask_req));

  // R12: combined line needs some source in the previous cycle
  p_req_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> $past((|wp_hit) | ext_mask_req | ext_nmi_req));
endmodule

// File: tb/wp_bp_qual_test.sv
module wp_bp_qual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wp_hit = '0, sw_en = '0, dp_en = '0, nm_en = '0;
  logic        rs = 1'b0;
  logic [1:0]  pwr = '0;
  logic [31:0] pval = '0;
  logic        em = 1'b0, enm = 1'b0;
  logic [3:0]  wp_pins, bp_pulse;
  logic        ext_bp, bp_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] wp;
    logic [3:0] bp;
    logic       ext;
    logic       any;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_cnt [2];
  logic [15:0] m_pre [2];

  always #5 clk = ~clk;

  wp_bp_qual uut (
    .clk(clk), .rst_n(rst_n), .wp_hit(wp_hit), .sw_trap_en(sw_en),
    .dp_trap_en(dp_en), .nomask_en(nm_en), .restartable(rs),
    .preset_wr(pwr), .preset_val(pval), .ext_mask_req(em),
    .ext_nmi_req(enm), .wp_pins(wp_pins), .bp_pulse(bp_pulse),
    .ext_bp(ext_bp), .bp_req(bp_req)
  );

  // Driver: computes expectations from the requirements, then advances one cycle
  task automatic tick(input string tag);
    exp_t e;
    logic q;
    e.wp = wp_hit;
    e.bp = '0;
    e.tag = tag;
    for (int i = 0; i < 4; i++) begin
      q = wp_hit[i] & (sw_en[i] | dp_en[i]) & (nm_en[i] | rs);
      if (i < 2) begin
        if (pwr[i]) begin
          m_pre[i] = pval[i*16 +: 16];
          m_cnt[i] = pval[i*16 +: 16];
        end else if (q) begin
          if (m_cnt[i] <= 16'd1) begin
            e.bp[i] = 1'b1;
            m_cnt[i] = m_pre[i];
          end else begin
            m_cnt[i] = m_cnt[i] - 16'd1;
          end
        end
      end else begin
        e.bp[i] = q;
      end
    end
    e.ext = enm | (em & rs);
    e.any = (|e.bp) | e.ext;
    sb.push_back(e);
    @(negedge clk);
    wp_hit = '0; pwr = '0; em = 1'b0; enm = 1'b0;
  endtask

  // Monitor: pops one expectation per cycle, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (wp_pins !== e.wp || bp_pulse !== e.bp || ext_bp !== e.ext || bp_req !== e.any) begin
        errors++;
        $display("FAIL %s: got wp=%b bp=%b ext=%b req=%b expected wp=%b bp=%b ext=%b req=%b",
                 e.tag, wp_pins, bp_pulse, ext_bp, bp_req, e.wp, e.bp, e.ext, e.any);
      end
    end
  end

  task automatic hits(input logic [3:0] h, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      wp_hit = h;
      tick(tag);
    end
  endtask

  initial begin
    m_cnt[0] = '0; m_cnt[1] = '0; m_pre[0] = '0; m_pre[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (wp_pins !== 4'b0 || bp_pulse !== 4'b0 || ext_bp !== 1'b0 || bp_req !== 1'b0) begin
      errors++;
      $display("FAIL R13: got wp=%b bp=%b ext=%b req=%b expected all zero",
               wp_pins, bp_pulse, ext_bp, bp_req);
    end

    // R1 / R2: nothing armed, pins still echo
    hits(4'b1111, 1, "R1 raw pins, unarmed");
    hits(4'b1010, 1, "R2 unarmed no breakpoint");
    // R13 / R5: reset preset 0 -> immediate fire on channel 0
    rs = 1'b1; sw_en = 4'b0001;
    hits(4'b0001, 2, "R13 immediate after reset");
    // R2: software-only and debug-port-only arming
    sw_en = 4'b0100; dp_en = 4'b1000;
    hits(4'b1100, 1, "R2 sw or dp arm");
    hits(4'b0011, 1, "R2 unarmed channels silent");
    // R3: masked, restartable low
    rs = 1'b0;
    hits(4'b1100, 1, "R3 masked blocked");
    // R8: dropped, not held
    tick("R8 no delayed breakpoint");
    rs = 1'b1;
    tick("R8 still nothing after restart");
    // R4: non-masked
    rs = 1'b0; nm_en = 4'b0100;
    hits(4'b1100, 1, "R4 non-masked passes");
    nm_en = 4'b0000; rs = 1'b1;

    // R6: preset 3 on channel 0
    sw_en = 4'b0001; dp_en = 4'b0000;
    pval = 32'h0000_0003; pwr = 2'b01;
    tick("R10 preset write ch0");
    hits(4'b0001, 6, "R6 every third match");
    // R7: channel 1 preset 2, masked matches frozen
    dp_en = 4'b0010;
    pval = 32'h0002_0000; pwr = 2'b10;
    tick("R10 preset write ch1");
    rs = 1'b0;
    hits(4'b0010, 3, "R7 masked matches not counted");
    rs = 1'b1;
    hits(4'b0010, 2, "R7 count resumes, second fires");
    // R9: disarm keeps count, unarmed matches ignored
    hits(4'b0001, 2, "R9 ch0 two of three");
    sw_en = 4'b0000;
    hits(4'b0001, 3, "R9 unarmed not counted");
    sw_en = 4'b0001;
    hits(4'b0001, 1, "R9 rearm fires on third");
    // R10: write wins over same-cycle match
    pval = 32'h0000_0002; pwr = 2'b01; wp_hit = 4'b0001;
    tick("R10 write beats match");
    hits(4'b0001, 2, "R10 reloaded count 2");
    // R5: preset 0 restores immediate mode
    pval = 32'h0000_0000; pwr = 2'b01;
    tick("R5 preset zero write");
    hits(4'b0001, 2, "R5 immediate mode");

    // R11 / R12: external requests
    em = 1'b1; tick("R11 maskable with restart");
    rs = 1'b0;
    em = 1'b1; tick("R11 maskable dropped");
    enm = 1'b1; tick("R11 non-maskable always");
    rs = 1'b1;
    em = 1'b1; wp_hit = 4'b0001; tick("R12 combined request");
    tick("R12 idle");

    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule